// File: doc/BRIEF.md
# Multiplexed ADC conversion sequencer

This block runs an external eight-input, 8-bit successive-approximation converter that has a handshake interface. A client raises a request with a 3-bit channel number. The sequencer accepts it only when it is idle. It then places the channel code on the converter's address lines and waits one full converter-clock period. Next it raises the address-latch strobe and the start pin together for a fixed number of system clocks. Both fall together, and the falling edge of start begins the conversion.

The sequencer then watches the end-of-conversion input. It waits for the line to drop (converter busy) and then to rise again (conversion finished). It drives output enable so the converter places its code on the data pins and registers the byte. It returns the byte with the channel number and a one-cycle valid pulse. If the handshake does not finish within a set number of converter-clock cycles, it returns an error result and goes back to idle. The converter clock is made by dividing the system clock and runs whenever the block is enabled.

Top module: `adc_seq`

## Requirements
- R1: While `en` is high, `adc_clk` toggles once every `DIV_HALF` system clocks. While `en` is low, and during reset, `adc_clk` is held low.
- R2: `req_ready` is high exactly when the block is idle and `en` is high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `adc_addr` then takes `req_ch` unchanged, in plain binary: code 0 selects input 0 and code 7 selects input 7, with bit 0 driving address line A. Requests made while `req_ready` is low are ignored and leave `adc_addr` unchanged.
- R3: `adc_ale` rises exactly 2*`DIV_HALF` system clocks after the accepting edge, which is one converter-clock period. `adc_addr` is stable across that rise.
- R4: `adc_ale` and `adc_start` rise together, stay high for exactly `STRB_CYC` system clocks, and fall together.
- R5: After `adc_start` falls, `adc_oe` stays low until `adc_eoc` has been seen low and then high again.
- R6: `adc_oe` is high for exactly two system clocks. The data is registered at the end of the first. `res_valid` is a one-cycle pulse in the second, and `adc_oe` is low in the cycle after the pulse.
- R7: A successful result carries `res_err` = 0, the requested channel on `res_ch`, and on `res_data` the 8-bit code the converter drove while `adc_oe` was high.
- R8: If the low-then-high `adc_eoc` sequence has not finished by the `TMO_CLKS`-th rising edge of `adc_clk` after start falls, the block pulses `res_valid` with `res_err` = 1 and `res_data` = 0, never raises `adc_oe`, and returns to idle.
- R9: Dropping `en` abandons any conversion in progress without a result and forces `adc_ale`, `adc_start` and `adc_oe` low. The block is idle again once `en` returns.
- R10: In reset, `adc_ale`, `adc_start`, `adc_oe`, `res_valid` and `adc_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; runs the converter clock |
| req_valid | input | 1 | Conversion request |
| req_ch | input | CH_W | Requested channel |
| req_ready | output | 1 | Idle and able to accept a request |
| adc_clk | output | 1 | Divided converter clock |
| adc_addr | output | CH_W | Channel address lines (bit 0 = A) |
| adc_ale | output | 1 | Address-latch strobe, latched on its rising edge |
| adc_start | output | 1 | Start pin; conversion begins on its falling edge |
| adc_eoc | input | 1 | End of conversion; low while busy |
| adc_oe | output | 1 | Output enable to the converter |
| adc_data | input | DW | Converter data pins |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | CH_W | Channel of the result |
| res_data | output | DW | Converted code, zero on error |
| res_err | output | 1 | Timeout flag qualifying `res_valid` |

## Verification
The embedded properties check several behaviours on every cycle. `adc_clk` is held low when the block is disabled, and the address is captured on acceptance and stable when the strobe rises. Output enable rises only after end-of-conversion was high, and the result strobe lasts one cycle. An error result never coincides with output enable. Other behaviours need the bench's converter model and cycle counts: the exact setup gap and strobe width, the two-cycle enable window, the data and channel returned for each input, the timeout window, and recovery after enable is dropped mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STRB,
      ST_WBUSY,
      ST_WDONE,
      ST_RDEN,
      ST_RDHOLD
   } seq_state_t;
endpackage

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen #(
   parameter int DIV_HALF = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic conv_clk,
   output logic rise_tick
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   conv_clk <= 1'b0;
            else if (!en) conv_clk <= 1'b0;
            else          conv_clk <= ~conv_clk;
         end
         assign rise_tick = en & ~conv_clk;
      end else begin : g_count
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt      <= '0;
               conv_clk <= 1'b0;
            end else if (!en) begin
               cnt      <= '0;
               conv_clk <= 1'b0;
            end else if (cnt == LAST) begin
               cnt      <= '0;
               conv_clk <= ~conv_clk;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign rise_tick = en & ~conv_clk & (cnt == LAST);
      end
   endgenerate

   // R1
   clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !conv_clk);
   // R1
   clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> conv_clk);
endmodule

// File: rtl/adc_seq_tmo.sv
module adc_seq_tmo #(
   parameter int LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("LIMIT must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (tick && cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign expired = tick & (cnt == LAST);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CH_W      = 3,
   parameter int DW        = 8,
   parameter int SETUP_CYC = 100,
   parameter int STRB_CYC  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            req_valid,
   input  logic [CH_W-1:0] req_ch,
   output logic            req_ready,
   input  logic            tmo_expired,
   output logic            tmo_clr,
   output logic [CH_W-1:0] adc_addr,
   output logic            adc_ale,
   output logic            adc_start,
   output logic            adc_oe,
   input  logic            adc_eoc,
   input  logic [DW-1:0]   adc_data,
   output logic            res_valid,
   output logic [CH_W-1:0] res_ch,
   output logic [DW-1:0]   res_data,
   output logic            res_err
);
   generate
      if (SETUP_CYC < 1 || STRB_CYC < 1) begin : g_bad_cyc
         $error("SETUP_CYC and STRB_CYC must be at least 1");
      end
   endgenerate

   localparam int MAXC = (SETUP_CYC > STRB_CYC) ? SETUP_CYC : STRB_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] STRB_LAST  = CW'(STRB_CYC - 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         adc_addr  <= '0;
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         res_ch    <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else begin
            unique case (state)
               ST_IDLE: if (req_valid) begin
                  adc_addr <= req_ch;
                  cnt      <= '0;
                  state    <= ST_SETUP;
               end
               ST_SETUP: if (cnt == SETUP_LAST) begin
                  cnt   <= '0;
                  state <= ST_STRB;
               end else cnt <= cnt + 1'b1;
               ST_STRB: if (cnt == STRB_LAST) begin
                  cnt   <= '0;
                  state <= ST_WBUSY;
               end else cnt <= cnt + 1'b1;
               ST_WBUSY, ST_WDONE: begin
                  if (state == ST_WBUSY && !adc_eoc) state <= ST_WDONE;
                  else if (state == ST_WDONE && adc_eoc) state <= ST_RDEN;
                  else if (tmo_expired) begin
                     res_valid <= 1'b1;
                     res_err   <= 1'b1;
                     res_ch    <= adc_addr;
                     res_data  <= '0;
                     state     <= ST_IDLE;
                  end
               end
               ST_RDEN: begin
                  res_data  <= adc_data;
                  res_ch    <= adc_addr;
                  res_valid <= 1'b1;
                  state     <= ST_RDHOLD;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign req_ready = en && (state == ST_IDLE);
   assign adc_ale   = (state == ST_STRB);
   assign adc_start = (state == ST_STRB);
   assign adc_oe    = (state == ST_RDEN) || (state == ST_RDHOLD);
   assign tmo_clr   = !((state == ST_WBUSY) || (state == ST_WDONE));

   // R2
   addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (adc_addr == $past(req_ch)));
   // R3
   ale_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_ale) |-> $stable(adc_addr));
   // R5
   oe_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_oe) |-> $past(adc_eoc));
   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R6
   valid_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_err) |-> adc_oe);
   // R8
   err_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_valid && !adc_oe));
   // R9
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!adc_ale && !adc_oe && !res_valid));
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
   parameter int CH_W     = 3,
   parameter int DW       = 8,
   parameter int DIV_HALF = 50,
   parameter int STRB_CYC = 4,
   parameter int TMO_CLKS = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            req_valid,
   input  logic [CH_W-1:0] req_ch,
   output logic            req_ready,
   output logic            adc_clk,
   output logic [CH_W-1:0] adc_addr,
   output logic            adc_ale,
   output logic            adc_start,
   input  logic            adc_eoc,
   output logic            adc_oe,
   input  logic [DW-1:0]   adc_data,
   output logic            res_valid,
   output logic [CH_W-1:0] res_ch,
   output logic [DW-1:0]   res_data,
   output logic            res_err
);
   localparam int SETUP_CYC = 2 * DIV_HALF;

   generate
      if (CH_W < 1 || DW < 1) begin : g_bad_width
         $error("CH_W and DW must be at least 1");
      end
   endgenerate

   logic rise_tick;
   logic tmo_clr;
   logic tmo_expired;

   adc_seq_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .conv_clk  (adc_clk),
      .rise_tick (rise_tick)
   );

   adc_seq_tmo #(.LIMIT(TMO_CLKS)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmo_clr),
      .tick    (rise_tick),
      .expired (tmo_expired)
   );

   adc_seq_fsm #(
      .CH_W      (CH_W),
      .DW        (DW),
      .SETUP_CYC (SETUP_CYC),
      .STRB_CYC  (STRB_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .req_valid   (req_valid),
      .req_ch      (req_ch),
      .req_ready   (req_ready),
      .tmo_expired (tmo_expired),
      .tmo_clr     (tmo_clr),
      .adc_addr    (adc_addr),
      .adc_ale     (adc_ale),
      .adc_start   (adc_start),
      .adc_oe      (adc_oe),
      .adc_eoc     (adc_eoc),
      .adc_data    (adc_data),
      .res_valid   (res_valid),
      .res_ch      (res_ch),
      .res_data    (res_data),
      .res_err     (res_err)
   );
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
   localparam int DH    = 3;
   localparam int STRB  = 4;
   localparam int TMO   = 20;
   localparam int BUSYD = 5;
   localparam int CONVD = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_ch = 3'd0;
   logic       req_ready, adc_clk, adc_ale, adc_start, adc_oe;
   logic       adc_eoc = 1'b1;
   logic [2:0] adc_addr, res_ch;
   logic [7:0] adc_data, res_data, mdl_val;
   logic       res_valid, res_err;

   int vectors = 0, miscompares = 0;
   bit done = 0;
   int mc = 0; bit mclk = 0;
   int mode = 0, exp_ch = 0, exp_data = 0, conv_idx = 0;
   bit pending = 0, armed = 0, in_wait = 0;
   int gap = 0, strb = 0, oecnt = 0, phase = 0, mcnt = 0, wcnt = 0;
   bit prev_ale = 0, prev_start = 0, prev_oe = 0;

   always #10 clk = ~clk;

   assign adc_data = adc_oe ? mdl_val : 8'h00;

   adc_seq #(.DIV_HALF(DH), .STRB_CYC(STRB), .TMO_CLKS(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_ch(req_ch),
      .req_ready(req_ready), .adc_clk(adc_clk), .adc_addr(adc_addr),
      .adc_ale(adc_ale), .adc_start(adc_start), .adc_eoc(adc_eoc), .adc_oe(adc_oe),
      .adc_data(adc_data), .res_valid(res_valid), .res_ch(res_ch),
      .res_data(res_data), .res_err(res_err));

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural converter-clock reference (R1)
   always @(posedge clk) begin
      if (!rst_n || !en) begin mc = 0; mclk = 0; end
      else if (mc == DH - 1) begin mc = 0; mclk = !mclk; end
      else mc++;
   end

   // monitor and converter model, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R10 adc_clk", int'(adc_clk), 0);
         chk("R10 strobes", int'({adc_ale, adc_start, adc_oe}), 0);
         chk("R10 res_valid", int'(res_valid), 0);
         chk("R2 ready in reset", int'(req_ready), 0);
      end else begin
         chk("R1 adc_clk", int'(adc_clk), int'(mclk));
         chk("R4 ale/start together", int'(adc_ale), int'(adc_start));
         if (!en) chk("R9 quiet while disabled", int'({adc_ale, adc_oe, req_ready}), 0);
         if (armed) begin
            if (!adc_ale) gap++;
            else begin
               chk("R3 setup gap", gap, 2 * DH);
               chk("R2 address code", int'(adc_addr), exp_ch);
               armed = 0;
            end
         end
         if (adc_ale && !prev_ale) begin
            mdl_val  = 8'((int'(adc_addr) * 37 + conv_idx * 11) & 255);
            exp_data = (exp_ch * 37 + conv_idx * 11) & 255;
            conv_idx++;
            adc_eoc = 1'b1; phase = 0;
         end
         if (adc_ale) strb++;
         else if (prev_ale) begin
            chk("R4 strobe width", strb, STRB);
            chk("R4 start falls with ale", int'(adc_start), 0);
            strb = 0;
         end
         if (adc_oe) begin
            chk("R5 oe only after done", int'(adc_eoc), 1);
            oecnt++;
         end else if (prev_oe) begin
            chk("R6 oe width", oecnt, 2);
            oecnt = 0;
         end
         if (prev_start && !adc_start) begin
            phase = 1; mcnt = 0; wcnt = 0; in_wait = 1;
         end else if (phase == 1) begin
            mcnt++;
            if (mcnt >= BUSYD && mode != 1) begin adc_eoc = 1'b0; phase = 2; mcnt = 0; end
         end else if (phase == 2) begin
            mcnt++;
            if (mcnt >= CONVD && mode != 2) begin adc_eoc = 1'b1; phase = 0; end
         end
         if (in_wait) wcnt++;
         if (res_valid) begin
            if (!pending) chk("R9 unexpected result", 1, 0);
            else begin
               chk("R7 res_ch", int'(res_ch), exp_ch);
               chk("R8 res_err", int'(res_err), int'(mode != 0));
               chk("R7 res_data", int'(res_data), (mode != 0) ? 0 : exp_data);
               chk("R6 oe during valid", int'(adc_oe), int'(mode == 0));
               if (mode != 0)
                  chk("R8 timeout window", int'(wcnt >= (TMO - 1) * 2 * DH && wcnt <= TMO * 2 * DH + 3), 1);
               pending = 0; in_wait = 0;
            end
         end
         prev_ale = adc_ale; prev_start = adc_start; prev_oe = adc_oe;
      end
   end

   task automatic convert(input int ch, input int m, input bit poke);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      #2;
      mode = m; exp_ch = ch; pending = 1; armed = 1; gap = 0;
      req_valid = 1'b1; req_ch = 3'(ch);
      @(negedge clk); #2;
      if (poke) begin
         req_ch = 3'(ch ^ 5);
         repeat (10) begin
            @(negedge clk);
            chk("R2 busy request ignored", int'(adc_addr), ch);
         end
         #2;
      end
      req_valid = 1'b0;
      while (pending) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R2 ready needs enable", int'(req_ready), 0);
      #2 en = 1'b1;
      @(negedge clk);
      chk("R2 ready when idle", int'(req_ready), 1);
      for (int c = 0; c < 8; c++) convert(c, 0, 0);
      convert(6, 0, 1);
      convert(2, 1, 0);
      convert(5, 2, 0);
      convert(3, 0, 0);
      // R9: drop enable mid-wait
      @(negedge clk); #2;
      mode = 2; exp_ch = 7; pending = 1; armed = 1; gap = 0;
      req_valid = 1'b1; req_ch = 3'd7;
      @(negedge clk); #2 req_valid = 1'b0;
      repeat (60) @(negedge clk);
      #2 en = 1'b0; pending = 0; in_wait = 0;
      repeat (10) @(negedge clk);
      chk("R9 clock stopped", int'(adc_clk), 0);
      #2 en = 1'b1;
      @(negedge clk);
      chk("R9 idle after re-enable", int'(req_ready), 1);
      convert(1, 0, 0);
      repeat (5) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule